// File: doc/BRIEF.md
# Symmetric / Asymmetric Decimating FIR Filter

This block filters a stream of 18-bit signed samples with a programmable FIR and emits one filtered result for every D accepted samples, where D is the decimation factor. A single multiply-accumulate engine is shared across all taps. It performs one multiply per clock, so a longer filter needs a larger decimation factor to finish each output before the next one is due.

In symmetric mode a mirrored pair of samples is combined before the multiply: added for even symmetry and subtracted for odd symmetry. One multiply then covers two taps, and up to 63 taps fit. With an odd tap count the middle sample is used alone. In odd symmetry the coefficient of that middle sample is treated as zero. Asymmetric mode applies up to 32 independent coefficients directly.

Coefficients are 16-bit signed fractions written through an address/data/write-enable port while the filter is idle. The sum is rounded, saturated to 18 bits and issued with a one-cycle strobe.

Top module: `sym_dec_fir`

## Requirements
- R1: With `cfg_sym`=1 and `cfg_odd`=0, the output equals sum over j of h[j]·x[n−j], where h[k]=h[N−1−k]=c[k] for k < ceil(N/2) and c is the coefficient held at address k.
- R2: With `cfg_sym`=1 and `cfg_odd`=1, h[k]=c[k] and h[N−1−k]=−c[k]. When N is odd, the centre tap h[(N−1)/2] is zero whatever is stored at its address.
- R3: With `cfg_sym`=0, h[j]=c[j] for j from 0 to N−1, with N from 1 to 32.
- R4: In symmetric mode every tap count from 1 to 63 is accepted, even or odd.
- R5: After reset, `out_valid` pulses once for accepted input number 0, D, 2D, and so on. Each result covers that input and the N−1 inputs before it, and inputs before reset count as zero.
- R6: A configuration is legal only if 1 ≤ D ≤ 64, N ≥ 1, N ≤ 63 (symmetric) or N ≤ 32 (asymmetric), and the multiply count (ceil(N/2) symmetric, N asymmetric) is at most D. Otherwise `cfg_err` is 1 and no `out_valid` is produced.
- R7: The result is the full-precision sum plus 2^14, arithmetically shifted right by 15, then clamped to the range −131072 to 131071.
- R8: While reset is high and in the cycle after it falls, `out_valid` is 0. Reset clears the sample history and the decimation phase.
- R9: Inputs may arrive on every clock, even when the multiply count equals D, without corrupting any result.
- R10: A write with `coef_we`=1 stores `coef_wdata` (16-bit two's complement) at `coef_addr` (0 to 31), and the value is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_taps | input | 6 | Tap count N |
| cfg_sym | input | 1 | 1 = symmetric mode |
| cfg_odd | input | 1 | 1 = odd (negating) symmetry |
| cfg_dec | input | 7 | Decimation factor D |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 5 | Coefficient address |
| coef_wdata | input | 16 | Coefficient value, signed Q1.15 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 18 | Input sample, signed |
| out_valid | output | 1 | Output strobe |
| out_data | output | 18 | Filtered, rounded, saturated output |
| cfg_err | output | 1 | Configuration illegal |

## Verification
The bench targets configurations where the multiply count exactly equals D, with samples arriving every clock. A design that read the history without accounting for samples shifted in during the computation would return values taken from the wrong window. Odd-length, odd-symmetry filters check that the centre coefficient is discarded; a design that kept it would show an error of about c·x. Rounding is probed at ±half an LSB, and full-scale inputs are used to force clamping. Illegal settings must keep `out_valid` low. A missing history reset shows up as a wrong first output in the case that follows.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int DATA_W        = 18;
    localparam int COEF_W        = 16;
    localparam int MAX_SYM_TAPS  = 63;
    localparam int MAX_ASYM_TAPS = 32;
    localparam int MAX_DEC       = 64;

    localparam int TAP_W   = $clog2(MAX_SYM_TAPS + 1);
    localparam int CADDR_W = $clog2(MAX_ASYM_TAPS);
    localparam int DEC_W   = $clog2(MAX_DEC + 1);
    localparam int IDX_W   = TAP_W + 1;
    localparam int PRE_W   = DATA_W + 1;
    localparam int PROD_W  = PRE_W + COEF_W;
    localparam int ACC_W   = PROD_W + CADDR_W;
    localparam int FRAC    = COEF_W - 1;

    localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI   = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_LO   = -(ACC_W'(1) <<< (DATA_W - 1));

    typedef struct packed {
        logic [TAP_W-1:0] taps;
        logic             sym;
        logic             odd;
        logic [DEC_W-1:0] dec;
    } fir_cfg_t;

    typedef enum logic {MAC_IDLE, MAC_RUN} mac_state_e;

    function automatic logic [TAP_W-1:0] mult_count(input fir_cfg_t c);
        if (c.sym) return TAP_W'((int'(c.taps) + 1) / 2);
        return c.taps;
    endfunction

    function automatic logic cfg_legal(input fir_cfg_t c);
        int n;
        n = int'(c.taps);
        if (n == 0 || c.dec == '0 || int'(c.dec) > MAX_DEC) return 1'b0;
        if (c.sym ? (n > MAX_SYM_TAPS) : (n > MAX_ASYM_TAPS)) return 1'b0;
        return int'(mult_count(c)) <= int'(c.dec);
    endfunction

    function automatic logic signed [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] t;
        t = (a + RND_HALF) >>> FRAC;
        if (t > SAT_HI) return DATA_W'(SAT_HI);
        if (t < SAT_LO) return DATA_W'(SAT_LO);
        return DATA_W'(t);
    endfunction
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int COEF_W = fir_pkg::COEF_W,
    parameter int DEPTH  = fir_pkg::MAX_ASYM_TAPS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic signed [COEF_W-1:0] wdata,
    input  logic [AW-1:0]            raddr,
    output logic signed [COEF_W-1:0] rdata
);
    logic signed [COEF_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // R10: a write is visible at its address on the following cycle
    p_coef_write_r10: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
    parameter int DATA_W = fir_pkg::DATA_W,
    parameter int DEPTH  = fir_pkg::MAX_SYM_TAPS,
    parameter int IDX_W  = fir_pkg::IDX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift_en,
    input  logic signed [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]         idx_a,
    input  logic [IDX_W-1:0]         idx_b,
    output logic signed [DATA_W-1:0] dout_a,
    output logic signed [DATA_W-1:0] dout_b
);
    logic signed [DATA_W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)           stage[0] <= '0;
        else if (shift_en) stage[0] <= din;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)           stage[g] <= '0;
            else if (shift_en) stage[g] <= stage[g-1];
        end
    end

    assign dout_a = (int'(idx_a) < DEPTH) ? stage[idx_a] : '0;
    assign dout_b = (int'(idx_b) < DEPTH) ? stage[idx_b] : '0;
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
    import fir_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  fir_cfg_t                  cfg,
    input  logic                      cfg_ok,
    input  logic [TAP_W-1:0]          mults,
    input  logic                      start,
    input  logic                      in_shift,
    input  logic signed [DATA_W-1:0]  samp_a,
    input  logic signed [DATA_W-1:0]  samp_b,
    input  logic signed [COEF_W-1:0]  coef,
    output logic [IDX_W-1:0]          idx_a,
    output logic [IDX_W-1:0]          idx_b,
    output logic [CADDR_W-1:0]        coef_addr,
    output logic                      out_valid,
    output logic signed [DATA_W-1:0]  out_data
);
    mac_state_e              state;
    logic [TAP_W-1:0]        step;
    logic [TAP_W-1:0]        arr;
    logic signed [ACC_W-1:0] acc;
    logic signed [PRE_W-1:0] pre;
    logic signed [COEF_W-1:0] coef_eff;
    logic signed [PROD_W-1:0] prod;
    logic                    busy, last, centre;

    assign busy      = (state == MAC_RUN);
    assign last      = busy && (step == mults - TAP_W'(1));
    assign centre    = cfg.sym && cfg.taps[0] && (step == mults - TAP_W'(1));
    assign coef_addr = step[CADDR_W-1:0];
    // arr counts samples shifted in since the start, so older data moved up
    assign idx_a = IDX_W'(step) + IDX_W'(arr);
    assign idx_b = IDX_W'(cfg.taps) - IDX_W'(1) - IDX_W'(step) + IDX_W'(arr);

    always_comb begin
        if (!cfg.sym || centre) pre = PRE_W'(samp_a);
        else if (cfg.odd)       pre = PRE_W'(samp_a) - PRE_W'(samp_b);
        else                    pre = PRE_W'(samp_a) + PRE_W'(samp_b);
        coef_eff = (centre && cfg.odd) ? '0 : coef;
        prod     = PROD_W'(pre) * PROD_W'(coef_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= MAC_IDLE;
            step      <= '0;
            arr       <= '0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (busy) begin
                acc  <= acc + ACC_W'(prod);
                step <= step + TAP_W'(1);
                if (in_shift) arr <= arr + TAP_W'(1);
                if (last) begin
                    out_valid <= cfg_ok;
                    out_data  <= round_sat(acc + ACC_W'(prod));
                    state     <= MAC_IDLE;
                end
            end
            if (start) begin
                state <= MAC_RUN;
                step  <= '0;
                arr   <= '0;
                acc   <= '0;
            end
            if (!cfg_ok) state <= MAC_IDLE;
        end
    end

    // R9: arrivals during a run never outpace the step count
    p_arr_bound_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> arr <= step);
    // R6: the run never steps past the multiply count
    p_step_bound_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> step < mults);
    // R6: an illegal setting leaves the engine silent
    p_quiet_on_err_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |=> !busy && !out_valid);
    // R5: a result only follows an active run
    p_out_after_run_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(busy));
endmodule

// File: rtl/sym_dec_fir.sv
module sym_dec_fir
    import fir_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_COEF_W = COEF_W,
    parameter int P_TAP_W  = TAP_W,
    parameter int P_DEC_W  = DEC_W,
    parameter int P_CADR_W = CADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [P_TAP_W-1:0]  cfg_taps,
    input  logic                cfg_sym,
    input  logic                cfg_odd,
    input  logic [P_DEC_W-1:0]  cfg_dec,
    input  logic                coef_we,
    input  logic [P_CADR_W-1:0] coef_addr,
    input  logic [P_COEF_W-1:0] coef_wdata,
    input  logic                in_valid,
    input  logic [P_DATA_W-1:0] in_data,
    output logic                out_valid,
    output logic [P_DATA_W-1:0] out_data,
    output logic                cfg_err
);
    fir_cfg_t                 cfg;
    logic                     ok, start;
    logic [DEC_W-1:0]         phase;
    logic [TAP_W-1:0]         mults;
    logic [IDX_W-1:0]         idx_a, idx_b;
    logic [CADDR_W-1:0]       rd_addr;
    logic signed [DATA_W-1:0] samp_a, samp_b, res;
    logic signed [COEF_W-1:0] coef;

    assign cfg     = '{taps: cfg_taps, sym: cfg_sym, odd: cfg_odd, dec: cfg_dec};
    assign ok      = cfg_legal(cfg);
    assign mults   = mult_count(cfg);
    assign cfg_err = !ok;
    assign start   = in_valid && ok && (phase == '0);

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else if (in_valid && ok)
            phase <= (phase == cfg.dec - DEC_W'(1)) ? '0 : phase + DEC_W'(1);
    end

    fir_coef_bank #(.COEF_W(COEF_W), .DEPTH(MAX_ASYM_TAPS)) u_coef (
        .clk(clk), .rst(rst), .we(coef_we), .waddr(coef_addr),
        .wdata($signed(coef_wdata)), .raddr(rd_addr), .rdata(coef));

    fir_tap_line #(.DATA_W(DATA_W), .DEPTH(MAX_SYM_TAPS), .IDX_W(IDX_W)) u_line (
        .clk(clk), .rst(rst), .shift_en(in_valid), .din($signed(in_data)),
        .idx_a(idx_a), .idx_b(idx_b), .dout_a(samp_a), .dout_b(samp_b));

    fir_mac_engine u_mac (
        .clk(clk), .rst(rst), .cfg(cfg), .cfg_ok(ok), .mults(mults),
        .start(start), .in_shift(in_valid), .samp_a(samp_a), .samp_b(samp_b),
        .coef(coef), .idx_a(idx_a), .idx_b(idx_b), .coef_addr(rd_addr),
        .out_valid(out_valid), .out_data(res));

    assign out_data = res;

    // R5: phase stays inside the decimation window
    p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
        ok |-> phase < cfg.dec);
    // R8: no result in the first cycle after reset
    p_reset_quiet_r8: assert property (@(posedge clk)
        $fell(rst) |-> !out_valid);
endmodule

// File: tb/sim_sym_dec_fir.sv
module sim_sym_dec_fir;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_taps = 6'd1;
    logic        cfg_sym = 1'b0, cfg_odd = 1'b0;
    logic [6:0]  cfg_dec = 7'd1;
    logic        coef_we = 1'b0;
    logic [4:0]  coef_addr = '0;
    logic [15:0] coef_wdata = '0;
    logic        in_valid = 1'b0;
    logic [17:0] in_data = '0;
    logic        out_valid, cfg_err;
    logic [17:0] out_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int cv [32];
    int xin [512];
    int n_in;
    int rx_q [$];

    always #2.5 clk = ~clk;

    sym_dec_fir u0 (.*);

    always @(negedge clk) if (!rst && out_valid) rx_q.push_back(int'($signed(out_data)));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: all reqs, actual hang, expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    // taps[16:11] sym[10] odd[9] dec[8:2] gap[1] err[0]
    localparam logic [16:0] CASES [13] = '{
        {6'd7,  1'b1, 1'b0, 7'd4,  1'b0, 1'b0},  // R1 R9
        {6'd8,  1'b1, 1'b0, 7'd4,  1'b1, 1'b0},  // R1 R4
        {6'd9,  1'b1, 1'b1, 7'd5,  1'b0, 1'b0},  // R2
        {6'd10, 1'b1, 1'b1, 7'd8,  1'b1, 1'b0},  // R2
        {6'd63, 1'b1, 1'b0, 7'd32, 1'b0, 1'b0},  // R4 R9
        {6'd32, 1'b0, 1'b0, 7'd32, 1'b0, 1'b0},  // R3 R9
        {6'd5,  1'b0, 1'b0, 7'd6,  1'b1, 1'b0},  // R3
        {6'd1,  1'b0, 1'b0, 7'd1,  1'b0, 1'b0},  // R5
        {6'd2,  1'b1, 1'b0, 7'd1,  1'b0, 1'b0},  // R5
        {6'd33, 1'b0, 1'b0, 7'd40, 1'b0, 1'b1},  // R6
        {6'd9,  1'b1, 1'b0, 7'd4,  1'b0, 1'b1},  // R6
        {6'd0,  1'b1, 1'b0, 7'd4,  1'b0, 1'b1},  // R6
        {6'd63, 1'b1, 1'b1, 7'd64, 1'b1, 1'b0}   // R2 R4
    };

    function automatic string tag_of(input int k);
        case (k)
            0: return "R1/R9";  1: return "R1/R4";  2, 3: return "R2";
            4: return "R4/R9";  5: return "R3/R9";  6: return "R3";
            7, 8: return "R5";  9, 10, 11: return "R6";
            12: return "R2/R4"; default: return "R7";
        endcase
    endfunction

    function automatic longint h_of(input int j, input int taps, input int sym, input int odd);
        int m;
        m = (taps + 1) / 2;
        if (sym == 0) return cv[j];
        if (j < m) begin
            if (odd != 0 && (taps % 2) == 1 && j == m - 1) return 0;
            return cv[j];
        end
        return (odd != 0) ? -cv[taps-1-j] : cv[taps-1-j];
    endfunction

    function automatic int model(input int n, input int taps, input int sym, input int odd);
        longint acc, r;
        acc = 0;
        for (int j = 0; j < taps; j++)
            if (n - j >= 0) acc += h_of(j, taps, sym, odd) * longint'(xin[n-j]);
        r = (acc + 16384) >>> 15;
        if (r > 131071) r = 131071;
        if (r < -131072) r = -131072;
        return int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int taps, input int sym, input int odd, input int dec,
                            input int gap, input int exp_err, input string req);
        int exp_q [$];
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        cfg_taps = 6'(taps); cfg_sym = sym[0]; cfg_odd = odd[0]; cfg_dec = 7'(dec);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 reset", int'(out_valid), 0);
        check(cfg_err == exp_err[0], {req, " R6 cfg_err"}, int'(cfg_err), exp_err);
        rst = 1'b0;
        rx_q.delete();
        check(out_valid == 1'b0, "R8 after reset", int'(out_valid), 0);
        for (int a = 0; a < 32; a++) begin  // R10 writes while idle
            coef_we = 1'b1; coef_addr = 5'(a); coef_wdata = 16'(cv[a]);
            @(negedge clk);
        end
        coef_we = 1'b0;
        for (int i = 0; i < n_in; i++) begin
            in_valid = 1'b1; in_data = 18'(xin[i]);
            @(negedge clk);
            in_valid = 1'b0;
            if (gap != 0) repeat (i % 3) @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (100) @(negedge clk);
        if (exp_err == 0)
            for (int n = 0; n < n_in; n += dec) exp_q.push_back(model(n, taps, sym, odd));
        check(rx_q.size() == exp_q.size(), {req, " output count"}, rx_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < rx_q.size(); k++)
            check(rx_q[k] == exp_q[k], {req, " value"}, rx_q[k], exp_q[k]);
    endtask

    initial begin
        int unsigned lcg;
        lcg = 32'h1234_5678;
        for (int k = 0; k < 13; k++) begin
            int taps, dec;
            taps = int'(CASES[k][16:11]);
            dec  = int'(CASES[k][8:2]);
            for (int a = 0; a < 32; a++) cv[a] = ((a * 7919 + k * 131 + 17) % 40001) - 20000;
            n_in = (dec == 0 ? 4 : dec) * 5 + 2;
            for (int i = 0; i < n_in; i++) begin
                lcg = lcg * 1664525 + 1013904223;
                xin[i] = int'($signed(lcg[31:14]));
            end
            run_case(taps, int'(CASES[k][10]), int'(CASES[k][9]), (dec == 0 ? 4 : dec),
                     int'(CASES[k][1]), int'(CASES[k][0]), tag_of(k));
        end
        // R7: clamp at the positive and negative limits
        for (int a = 0; a < 32; a++) cv[a] = 32767;
        n_in = 12;
        for (int i = 0; i < n_in; i++) xin[i] = 131071;
        run_case(4, 0, 0, 4, 0, 0, "R7 sat+");
        for (int i = 0; i < n_in; i++) xin[i] = -131072;
        run_case(4, 0, 0, 4, 0, 0, "R7 sat-");
        // R7: rounding at half an LSB
        for (int a = 0; a < 32; a++) cv[a] = 0;
        cv[0] = 1;
        xin[0] = 16384; xin[1] = 16383; xin[2] = -16384; xin[3] = -16385;
        xin[4] = 49152; xin[5] = -49152; xin[6] = 131071; xin[7] = -131072;
        n_in = 8;
        run_case(1, 0, 0, 1, 0, 0, "R7 round");
        // R2: centre coefficient large, odd symmetry must discard it
        for (int a = 0; a < 32; a++) cv[a] = 0;
        cv[2] = 30000;
        n_in = 10;
        for (int i = 0; i < n_in; i++) xin[i] = 100000;
        run_case(5, 1, 1, 3, 0, 0, "R2 centre");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule